// File: doc/BRIEF.md
# Amplifier offset calibration sequencer

This block runs the offset-trim search for a single on-chip amplifier without software in the loop. A start pulse launches a pass over up to four calibration targets. Each target pairs an operating mode (normal or high-speed) with an input differential pair (N or P). For each target the sequencer applies a 5-bit trim code, begins at zero and raises the code by one at each step. After every new code it waits a programmable number of settling cycles and then samples the amplifier's comparator output. The first code at which the comparator reads low is the result. It is sent out on the trim bus together with a write strobe that names the destination field.

The surrounding logic owns the trim registers. A normal-mode register and a high-speed register each keep the N result in bits 4:0 and the P result in bits 12:8. The sequencer only provides the value and one strobe per field. The analog core, the reference generator and any bus access are outside the block.

Top module: `offcal_seq`

## Requirements
- R1: A start pulse accepted while idle sets busy, amplifier enable and user-trim select in the first busy cycle with calibration mode still off. Calibration mode turns on one cycle later. Enable and user-trim select stay high after the run ends.
- R2: Within one target the trim output starts at 0 and only ever rises by exactly one per step.
- R3: After a new trim code is applied, the comparator is sampled only after the code has been held for settle_cycles_i+1 cycles. Each step therefore lasts settle_cycles_i+2 cycles, and a whole run is busy for 3 + sum over requested targets of (1 + (result+1)*(settle_cycles_i+2)) cycles.
- R4: The result of a target is the first code at which the comparator reads 0. It is present on trim_o in the single cycle in which that target's write strobe is high.
- R5: Mask bit 0 selects normal/N, bit 1 normal/P, bit 2 high-speed/N and bit 3 high-speed/P. Requested targets run in that bit order. A target whose bit is clear is skipped and its strobe never pulses.
- R6: N-pair targets drive reference select 2'b11 and P-pair targets drive 2'b01. High-speed select is 0 for normal-mode targets and 1 for high-speed targets, and both hold these values while the strobe is high.
- R7: If the comparator still reads 1 at code 31, the result is 31 and fail bit k (same bit numbering as the mask) is set. Fail bits stay set until the next accepted start clears them.
- R8: When the last requested target finishes, calibration mode and busy fall on the same edge. Done is high for exactly one cycle, the cycle after that edge.
- R9: A start pulse that arrives while busy has no effect on the run in progress, its results or its length.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a calibration run |
| mode_mask_i | input | 4 | Targets to calibrate, sampled at start |
| settle_cycles_i | input | SETTLE_W | Settling wait per step, sampled at start |
| cmp_i | input | 1 | Amplifier comparator result |
| amp_en_o | output | 1 | Amplifier enable |
| hs_sel_o | output | 1 | High-speed mode select |
| cal_on_o | output | 1 | Calibration mode, isolates amplifier inputs |
| ref_sel_o | output | 2 | Calibration reference select |
| user_trim_o | output | 1 | Selects user trim values over factory values |
| trim_o | output | TRIM_W | Trim code under test, and the result during a strobe |
| wr_norm_n_o | output | 1 | Write strobe, normal-mode N field |
| wr_norm_p_o | output | 1 | Write strobe, normal-mode P field |
| wr_hs_n_o | output | 1 | Write strobe, high-speed N field |
| wr_hs_p_o | output | 1 | Write strobe, high-speed P field |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 4 | Sticky per-target no-transition flags |

## Verification
The checks that run on every cycle cover the following rules: calibration mode never appears without enable and user-trim select, trim codes only rise in unit steps, a sample is always preceded by an expired settle count, at most one strobe is active and it matches the reference and mode selects, fail bits do not clear during a run, and done is a lone pulse while idle. Whether a stored code is the right one, whether targets run in mask order, whether skipped targets stay unwritten, whether the run length fits the settle formula and whether a start during a run is ignored are shown only by the bench. The bench does this with a comparator model whose output lags each new code by the settle interval.

// File: rtl/offcal_pkg.sv
package offcal_pkg;
  localparam int NUM_TGT = 4;
  localparam int TGT_W   = $clog2(NUM_TGT);
  localparam logic [1:0] REF_N = 2'b11;
  localparam logic [1:0] REF_P = 2'b01;

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_NEXT, S_WAIT, S_TEST, S_FIN
  } seq_state_t;
endpackage

// File: rtl/offcal_settle_timer.sv
module offcal_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R3: the wait shortens by one cycle per running cycle
  assert_countdown_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/offcal_tgt_pick.sv
module offcal_tgt_pick #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [N-1:0]   pending,
  output logic           any,
  output logic [IDW-1:0] idx
);
  always_comb begin
    any = |pending;
    idx = '0;
    for (int k = N - 1; k >= 0; k--)
      if (pending[k]) idx = k[IDW-1:0];
  end
endmodule

// File: rtl/offcal_tgt_dec.sv
module offcal_tgt_dec
  import offcal_pkg::*;
(
  input  logic [TGT_W-1:0]   idx,
  output logic               hs,
  output logic [1:0]         refsel,
  output logic [NUM_TGT-1:0] onehot
);
  assign hs     = idx[1];
  assign refsel = idx[0] ? REF_P : REF_N;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_oh
    assign onehot[g] = (idx == g[TGT_W-1:0]);
  end
endmodule

// File: rtl/offcal_seq.sv
module offcal_seq
  import offcal_pkg::*;
#(
  parameter int TRIM_W   = 5,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [3:0]          mode_mask_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                cmp_i,
  output logic                amp_en_o,
  output logic                hs_sel_o,
  output logic                cal_on_o,
  output logic [1:0]          ref_sel_o,
  output logic                user_trim_o,
  output logic [TRIM_W-1:0]   trim_o,
  output logic                wr_norm_n_o,
  output logic                wr_norm_p_o,
  output logic                wr_hs_n_o,
  output logic                wr_hs_p_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [3:0]          fail_o
);
  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;

  seq_state_t           st;
  logic [NUM_TGT-1:0]   pending_q, cur_oh_q, wr_q, fail_q;
  logic [SETTLE_W-1:0]  settle_q;
  logic [TRIM_W-1:0]    trim_q;
  logic                 amp_en_q, user_q, cal_q, hs_q, busy_q, done_q;
  logic [1:0]           ref_q;

  logic                 pick_any;
  logic [TGT_W-1:0]     pick_idx;
  logic                 dec_hs;
  logic [1:0]           dec_ref;
  logic [NUM_TGT-1:0]   dec_oh;
  logic                 tmr_load, tmr_expired, step_again, tgt_end;

  offcal_tgt_pick #(.N(NUM_TGT), .IDW(TGT_W)) u_pick (
    .pending(pending_q), .any(pick_any), .idx(pick_idx));

  offcal_tgt_dec u_dec (
    .idx(pick_idx), .hs(dec_hs), .refsel(dec_ref), .onehot(dec_oh));

  assign tgt_end    = !cmp_i || (trim_q == TRIM_MAX);
  assign step_again = (st == S_TEST) && !tgt_end;
  assign tmr_load   = ((st == S_NEXT) && pick_any) || step_again;

  offcal_settle_timer #(.CNT_W(SETTLE_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(settle_q),
    .run(st == S_WAIT), .expired(tmr_expired));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      pending_q <= '0;
      cur_oh_q  <= '0;
      wr_q      <= '0;
      fail_q    <= '0;
      settle_q  <= '0;
      trim_q    <= '0;
      amp_en_q  <= 1'b0;
      user_q    <= 1'b0;
      cal_q     <= 1'b0;
      hs_q      <= 1'b0;
      ref_q     <= 2'b00;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wr_q   <= '0;
      case (st)
        S_IDLE: if (start_i) begin
          busy_q    <= 1'b1;
          amp_en_q  <= 1'b1;
          user_q    <= 1'b1;
          pending_q <= mode_mask_i;
          settle_q  <= settle_cycles_i;
          fail_q    <= '0;
          st        <= S_ARM;
        end
        S_ARM: begin
          cal_q <= 1'b1;
          st    <= S_NEXT;
        end
        S_NEXT: if (pick_any) begin
          hs_q      <= dec_hs;
          ref_q     <= dec_ref;
          cur_oh_q  <= dec_oh;
          trim_q    <= '0;
          pending_q <= pending_q & ~dec_oh;
          st        <= S_WAIT;
        end else begin
          st <= S_FIN;
        end
        S_WAIT: if (tmr_expired) st <= S_TEST;
        S_TEST: if (tgt_end) begin
          wr_q <= cur_oh_q;
          if (cmp_i) fail_q <= fail_q | cur_oh_q;
          st <= S_NEXT;
        end else begin
          trim_q <= trim_q + 1'b1;
          st     <= S_WAIT;
        end
        S_FIN: begin
          cal_q  <= 1'b0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign amp_en_o    = amp_en_q;
  assign user_trim_o = user_q;
  assign cal_on_o    = cal_q;
  assign hs_sel_o    = hs_q;
  assign ref_sel_o   = ref_q;
  assign trim_o      = trim_q;
  assign wr_norm_n_o = wr_q[0];
  assign wr_norm_p_o = wr_q[1];
  assign wr_hs_n_o   = wr_q[2];
  assign wr_hs_p_o   = wr_q[3];
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;

  // R1: calibration mode only with the amplifier enabled on user trims
  assert_calon_gated_R1: assert property (@(posedge clk) disable iff (rst)
    cal_on_o |-> (amp_en_o && user_trim_o));

  // R2: trim code only rises in unit steps (or restarts at zero)
  assert_unit_step_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && trim_o != $past(trim_o) && trim_o != '0)
      |-> trim_o == TRIM_W'($past(trim_o) + 1'b1));

  // R3: a sample follows an expired settle wait
  assert_sample_settled_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_TEST) |-> ($past(st) == S_WAIT && $past(tmr_expired)));

  // R5: one destination at a time
  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_hs_p_o, wr_hs_n_o, wr_norm_p_o, wr_norm_n_o}));

  // R6: selects match the destination field
  assert_ref_n_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_norm_n_o || wr_hs_n_o) |-> ref_sel_o == REF_N);
  assert_ref_p_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_norm_p_o || wr_hs_p_o) |-> ref_sel_o == REF_P);
  assert_hs_mode_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_hs_n_o || wr_hs_p_o) |-> hs_sel_o);
  assert_norm_mode_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_norm_n_o || wr_norm_p_o) |-> !hs_sel_o);

  // R7: fail flags are sticky inside a run
  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ((fail_o & $past(fail_o)) == $past(fail_o)));

  // R8: done is a lone pulse while idle with calibration off
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !cal_on_o));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: tb/sim_offcal_seq.sv
module sim_offcal_seq;
  localparam int TRIM_W   = 5;
  localparam int SETTLE_W = 16;
  // vector: [35:32] mask, [31:24] settle, then 6-bit thresholds tgt3..tgt0
  localparam int NVEC = 6;
  localparam logic [35:0] VEC [NVEC] = '{
    {4'hF, 8'd3, 6'd17, 6'd0,  6'd9,  6'd5 },
    {4'h5, 8'd0, 6'd7,  6'd31, 6'd3,  6'd12},
    {4'hA, 8'd7, 6'd22, 6'd2,  6'd40, 6'd1 },
    {4'h0, 8'd2, 6'd1,  6'd1,  6'd1,  6'd1 },
    {4'h8, 8'd1, 6'd63, 6'd0,  6'd0,  6'd0 },
    {4'h6, 8'd5, 6'd0,  6'd6,  6'd0,  6'd4 }
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [3:0] mode_mask_i = '0;
  logic [SETTLE_W-1:0] settle_cycles_i = '0;
  logic cmp_i = 1'b1;
  logic amp_en_o, hs_sel_o, cal_on_o, user_trim_o;
  logic [1:0] ref_sel_o;
  logic [TRIM_W-1:0] trim_o;
  logic wr_norm_n_o, wr_norm_p_o, wr_hs_n_o, wr_hs_p_o, busy_o, done_o;
  logic [3:0] fail_o;

  always #5 clk = ~clk;

  offcal_seq #(.TRIM_W(TRIM_W), .SETTLE_W(SETTLE_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_mask_i(mode_mask_i),
    .settle_cycles_i(settle_cycles_i), .cmp_i(cmp_i), .amp_en_o(amp_en_o),
    .hs_sel_o(hs_sel_o), .cal_on_o(cal_on_o), .ref_sel_o(ref_sel_o),
    .user_trim_o(user_trim_o), .trim_o(trim_o), .wr_norm_n_o(wr_norm_n_o),
    .wr_norm_p_o(wr_norm_p_o), .wr_hs_n_o(wr_hs_n_o), .wr_hs_p_o(wr_hs_p_o),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o));

  int n_chk = 0;
  int n_bad = 0;
  int thr [4];
  int s_cur = 0;

  // comparator model: follows the code only once it has been held long enough
  logic [7:0] last_key = '0;
  int stab = 0;
  always @(negedge clk) begin
    logic [7:0] key;
    int idx;
    key = {hs_sel_o, ref_sel_o, trim_o};
    idx = {30'd0, hs_sel_o, (ref_sel_o == 2'b01)};
    if (key != last_key) begin
      last_key <= key;
      stab <= 1;
    end else begin
      if (stab < 100000) stab <= stab + 1;
      if (stab >= s_cur + 1) cmp_i <= (int'(trim_o) < thr[idx]);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [35:0] v, input int inject);
    logic [3:0] mask;
    int got [4];
    int wcnt [4];
    int last_k, busy_cnt, exp_busy, cyc, step_bad, sel_bad, order_bad, done_seen;
    logic [3:0] exp_fail;
    logic [TRIM_W-1:0] prev_trim;
    mask = v[35:32];
    s_cur = int'(v[31:24]);
    for (int k = 0; k < 4; k++) begin
      thr[k] = int'(v[6*k +: 6]);
      got[k] = -1;
      wcnt[k] = 0;
    end
    @(negedge clk);
    mode_mask_i = mask;
    settle_cycles_i = SETTLE_W'(s_cur);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && amp_en_o && user_trim_o && !cal_on_o, "R1 first busy cycle",
        {busy_o, amp_en_o, user_trim_o, cal_on_o}, 4'b1110);
    busy_cnt = 0; cyc = 0; step_bad = 0; sel_bad = 0; order_bad = 0;
    last_k = -1; done_seen = 0; prev_trim = trim_o;
    while (cyc < 20000) begin
      if (cyc == 1)
        chk(cal_on_o, "R1 calibration on second cycle", cal_on_o, 1);
      if (busy_o) busy_cnt++;
      if (busy_o && trim_o != prev_trim && trim_o != '0 && trim_o != prev_trim + 1'b1)
        step_bad++;
      prev_trim = trim_o;
      for (int k = 0; k < 4; k++) begin
        if ({wr_hs_p_o, wr_hs_n_o, wr_norm_p_o, wr_norm_n_o} & (4'b1 << k)) begin
          got[k] = int'(trim_o);
          wcnt[k]++;
          if (k <= last_k) order_bad++;
          last_k = k;
          if (hs_sel_o != k[1] || ref_sel_o != (k[0] ? 2'b01 : 2'b11)) sel_bad++;
        end
      end
      if (inject > 0 && cyc == inject) begin
        mode_mask_i = 4'h1;
        settle_cycles_i = '0;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (done_o) begin
        done_seen = 1;
        break;
      end
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(done_seen == 1, "R8 run completes", done_seen, 1);
    chk(!busy_o && !cal_on_o, "R8 busy and calibration off at done",
        {busy_o, cal_on_o}, 0);
    chk(amp_en_o && user_trim_o, "R1 enable and user trim held", {amp_en_o, user_trim_o}, 3);
    chk(step_bad == 0, "R2 unit trim steps", step_bad, 0);
    chk(sel_bad == 0, "R6 selects at strobe", sel_bad, 0);
    chk(order_bad == 0, "R5 target order", order_bad, 0);
    exp_busy = 3;
    exp_fail = '0;
    for (int k = 0; k < 4; k++) begin
      int r;
      r = (thr[k] > 31) ? 31 : thr[k];
      if (mask[k]) begin
        exp_busy += 1 + (r + 1) * (s_cur + 2);
        chk(wcnt[k] == 1 && got[k] == r, "R4 stored result", got[k], r);
        if (thr[k] > 31) exp_fail[k] = 1'b1;
      end else begin
        chk(wcnt[k] == 0, "R5 skipped target not written", wcnt[k], 0);
      end
    end
    chk(busy_cnt == exp_busy, inject > 0 ? "R9 start while busy ignored" : "R3 run length",
        busy_cnt, exp_busy);
    chk(fail_o == exp_fail, "R7 fail flags", fail_o, exp_fail);
    @(negedge clk);
    chk(!done_o, "R8 done single cycle", done_o, 0);
    chk(fail_o == exp_fail, "R7 fail flags held after run", fail_o, exp_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk({amp_en_o, hs_sel_o, cal_on_o, ref_sel_o, user_trim_o, trim_o, wr_norm_n_o,
         wr_norm_p_o, wr_hs_n_o, wr_hs_p_o, busy_o, done_o, fail_o} == '0,
        "R10 outputs after reset", int'(trim_o), 0);
    for (int i = 0; i < NVEC; i++) run_case(VEC[i], 0);
    // R9 start pulse during a run
    run_case(VEC[0], 40);
    // R7 fail flags cleared by the next accepted start
    run_case(VEC[4], 0);
    run_case(VEC[3], 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule